// File: doc/BRIEF.md
# Clear-on-read interrupt aggregator

This block collects interrupt events from a set of framer channels and folds them into a single active-low interrupt request. Each channel owns a bank of status registers. Each bit of a status register has its own enable in a bit-mask register, and each status register feeds one bit of the interrupt vector. A per-channel vector mask can silence a whole register without touching its bit masks. The request pin is modelled as a constant low data value plus a registered output enable. The enable is high while any enabled vector bit is set.

Software reaches status, masks and per-channel control through a single-cycle read/write port. Reading a status register returns its content and clears it in the same cycle. Each channel has a suspend control that gates only its vector bits. It also has a live control that holds its status cleared. A channel reset returns its masks and controls to their reset values. A global hold input keeps every status register cleared and the request inactive, for example during power-up. Channel count, registers per channel and register width are parameters.

Top module: `irq_aggr`

## Requirements
- R1: The address is {channel, space[1:0], register}. In space 0 a read of a status register returns its bits. A status bit is set by a high event bit in any cycle where its bit-mask bit (space 1, 1 = masked) is 0. A masked event bit leaves the status bit unchanged.
- R2: `irq_o` is always 0. `irq_oe_o` is 1 in the cycle after any status register is nonzero while its vector bit is enabled, its channel's enable bit is 1 and `hold_ni` is 1. In every other case it is 0.
- R3: A read gives `rvalid_o` = 1 and `rdata_o` in the next cycle. A read of a status register clears that register at the same edge.
- R4: `irq_oe_o` stays 1 until every contributing status register has been read. It drops one cycle after the last one clears.
- R5: If an event bit arrives in the same cycle as a read of its register, the read returns the old value and the new bit stays set for the next read.
- R6: In space 2, bit r of a channel's vector mask (1 = masked) stops status register r from driving `irq_oe_o`. That register still sets on events and clears on read.
- R7: In space 3, control bit 0 is the channel enable. When it is 0, the channel cannot drive `irq_oe_o`, but its status still sets and clears on read.
- R8: In space 3, control bit 1 is the channel live bit. When it is 0, all of that channel's status registers are held at zero and ignore events.
- R9: While `hold_ni` is 0, every status register is cleared and not updated, and `irq_oe_o` is 0 in the following cycle. Bit masks keep their contents.
- R10: After `rst_ni`, or after a write of control bit 2 = 1 to a channel, that channel's bit masks and vector mask read 0 and its control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_ni | input | 1 | Global hold, low keeps all status cleared and the request off |
| evt_i | input | NUM_CH*NREG*DW | Raw event bits, register index = channel*NREG + register |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | CH_W+2+RG_W | {channel, space, register} |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Request pin data, constant low |
| irq_oe_o | output | 1 | Request pin output enable, high means the pin is driven low |

## Verification
The hardest case to reach is a read that collides with a fresh event on the same register. The read must return the old value while the new bit survives. The bench drives the event and the read strobe in the same cycle and then reads the register a second time. A similar difficulty is keeping the request up while several registers, in different channels, are drained one by one. To reach it, the stimulus fills registers in two channels, reads them in sequence and checks the enable after each read. A reference model tracks the request enable every cycle, so masking, suspend, live and hold phases are compared cycle by cycle as well.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  typedef enum logic [1:0] {
    SP_STAT  = 2'd0,
    SP_BMASK = 2'd1,
    SP_VMASK = 2'd2,
    SP_CTRL  = 2'd3
  } space_e;

  localparam int CTL_EN  = 0;
  localparam int CTL_LIVE = 1;
  localparam int CTL_RST = 2;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int NREG = 4,
  parameter int DW   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_ni,
  input  logic               live_i,
  input  logic               chan_rst_i,
  input  logic [NREG*DW-1:0] evt_i,
  input  logic [NREG-1:0]    rd_clr_i,
  input  logic [NREG-1:0]    mask_we_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NREG*DW-1:0] stat_o,
  output logic [NREG*DW-1:0] mask_o,
  output logic [NREG-1:0]    nz_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [DW-1:0] st_q, mk_q;

    // event set dominates read clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                st_q <= '0;
      else if (!hold_ni || !live_i) st_q <= '0;
      else st_q <= (rd_clr_i[r] ? '0 : st_q) | (evt_i[r*DW +: DW] & ~mk_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mk_q <= '0;
      else if (chan_rst_i)   mk_q <= '0;
      else if (mask_we_i[r]) mk_q <= wdata_i;
    end

    assign stat_o[r*DW +: DW] = st_q;
    assign mask_o[r*DW +: DW] = mk_q;
    assign nz_o[r]            = |st_q;
  end
endmodule

// File: rtl/irq_chan_ctrl.sv
module irq_chan_ctrl #(
  parameter int NREG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctl_we_i,
  input  logic            vm_we_i,
  input  logic [2:0]      ctl_wdata_i,
  input  logic [NREG-1:0] vm_wdata_i,
  output logic            en_o,
  output logic            live_o,
  output logic [NREG-1:0] vmask_o,
  output logic            chan_rst_o
);
  import irq_aggr_pkg::*;

  assign chan_rst_o = ctl_we_i && ctl_wdata_i[CTL_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      live_o  <= 1'b0;
      vmask_o <= '0;
    end else if (chan_rst_o) begin
      en_o    <= 1'b0;
      live_o  <= 1'b0;
      vmask_o <= '0;
    end else begin
      if (ctl_we_i) begin
        en_o   <= ctl_wdata_i[CTL_EN];
        live_o <= ctl_wdata_i[CTL_LIVE];
      end
      if (vm_we_i) vmask_o <= vm_wdata_i;
    end
  end
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr #(
  parameter  int NUM_CH = 8,
  parameter  int NREG   = 4,
  parameter  int DW     = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RG_W   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW     = CH_W + 2 + RG_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      hold_ni,
  input  logic [NUM_CH*NREG*DW-1:0] evt_i,
  input  logic                      rd_en_i,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  output logic                      rvalid_o,
  output logic                      irq_o,
  output logic                      irq_oe_o
);
  import irq_aggr_pkg::*;

  localparam int NTOT = NUM_CH * NREG;

  logic [CH_W-1:0]    a_ch;
  space_e             a_sp;
  logic [RG_W-1:0]    a_rg;
  logic [NTOT*DW-1:0] stat_all, mask_all;
  logic [NTOT-1:0]    nz_all, vm_all, vec;
  logic [NUM_CH-1:0]  en_all, live_all;
  logic [DW-1:0]      rd_mux;
  logic               oe_q;

  assign a_ch = addr_i[AW-1 -: CH_W];
  assign a_sp = space_e'(addr_i[RG_W +: 2]);
  assign a_rg = addr_i[RG_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic            ch_sel, chan_rst;
    logic [NREG-1:0] rd_clr, mask_we;

    assign ch_sel = (a_ch == CH_W'(c));
    for (genvar r = 0; r < NREG; r++) begin : g_dec
      assign rd_clr[r]  = rd_en_i && ch_sel && a_sp == SP_STAT  && a_rg == RG_W'(r);
      assign mask_we[r] = wr_en_i && ch_sel && a_sp == SP_BMASK && a_rg == RG_W'(r);
    end

    irq_chan_ctrl #(.NREG(NREG)) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctl_we_i   (wr_en_i && ch_sel && a_sp == SP_CTRL),
      .vm_we_i    (wr_en_i && ch_sel && a_sp == SP_VMASK),
      .ctl_wdata_i(wdata_i[2:0]),
      .vm_wdata_i (wdata_i[NREG-1:0]),
      .en_o       (en_all[c]),
      .live_o     (live_all[c]),
      .vmask_o    (vm_all[c*NREG +: NREG]),
      .chan_rst_o (chan_rst)
    );

    irq_stat_bank #(.NREG(NREG), .DW(DW)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hold_ni   (hold_ni),
      .live_i    (live_all[c]),
      .chan_rst_i(chan_rst),
      .evt_i     (evt_i[c*NREG*DW +: NREG*DW]),
      .rd_clr_i  (rd_clr),
      .mask_we_i (mask_we),
      .wdata_i   (wdata_i),
      .stat_o    (stat_all[c*NREG*DW +: NREG*DW]),
      .mask_o    (mask_all[c*NREG*DW +: NREG*DW]),
      .nz_o      (nz_all[c*NREG +: NREG])
    );

    assign vec[c*NREG +: NREG] = nz_all[c*NREG +: NREG] & ~vm_all[c*NREG +: NREG]
                                 & {NREG{en_all[c]}};
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (a_ch == CH_W'(c)) begin
        case (a_sp)
          SP_VMASK: rd_mux = DW'(vm_all[c*NREG +: NREG]);
          SP_CTRL:  rd_mux = DW'({live_all[c], en_all[c]});
          default: begin
            for (int r = 0; r < NREG; r++) begin
              if (a_rg == RG_W'(r))
                rd_mux = (a_sp == SP_STAT) ? stat_all[(c*NREG+r)*DW +: DW]
                                           : mask_all[(c*NREG+r)*DW +: DW];
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q     <= 1'b0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      oe_q     <= hold_ni && (|vec);
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  assign irq_o    = 1'b0;
  assign irq_oe_o = oe_q;
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
  parameter  int NUM_CH = 8,
  parameter  int NREG   = 4,
  parameter  int DW     = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RG_W   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW     = CH_W + 2 + RG_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      hold_ni,
  input logic                      rd_en_i,
  input logic [AW-1:0]             addr_i,
  input logic [NUM_CH*NREG*DW-1:0] evt_i,
  input logic [NUM_CH*NREG*DW-1:0] stat_all,
  input logic [NUM_CH-1:0]         en_all,
  input logic                      rvalid_o,
  input logic                      irq_oe_o
);
  logic        rd_stat;
  int          idx, idx_q;
  logic [DW-1:0] evt_sel, st_sel;

  assign rd_stat = rd_en_i && addr_i[RG_W +: 2] == 2'd0
                   && int'(addr_i[AW-1 -: CH_W]) < NUM_CH
                   && int'(addr_i[RG_W-1:0]) < NREG;
  assign idx     = rd_stat ? int'(addr_i[AW-1 -: CH_W]) * NREG + int'(addr_i[RG_W-1:0]) : 0;
  assign evt_sel = evt_i[idx*DW +: DW];
  assign st_sel  = stat_all[idx_q*DW +: DW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= 0;
    else         idx_q <= idx;
  end

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat && evt_sel == '0 |=> st_sel == '0); // R3
  AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R3
  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ni |=> !irq_oe_o); // R9
  AST_IDLE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_all == '0 |=> !irq_oe_o); // R4
  AST_ALL_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_all == '0 |=> !irq_oe_o); // R7
endmodule

bind irq_aggr irq_aggr_chk #(.NUM_CH(NUM_CH), .NREG(NREG), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hold_ni (hold_ni),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .evt_i   (evt_i),
  .stat_all(stat_all),
  .en_all  (en_all),
  .rvalid_o(rvalid_o),
  .irq_oe_o(irq_oe_o)
);

// File: tb/tb_irq_aggr.sv
module tb_irq_aggr;
  localparam int NUM_CH = 2;
  localparam int NREG   = 3;
  localparam int DW     = 16;
  localparam int CH_W   = 1;
  localparam int RG_W   = 2;
  localparam int AW     = CH_W + 2 + RG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_n = 1'b1;
  logic [NUM_CH*NREG*DW-1:0] evt = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, irq, irq_oe;
  int t_ch = 0, t_sp = 0, t_rg = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DW-1:0] q_exp[$];
  string q_tag[$];

  always #10 clk = ~clk;

  irq_aggr #(.NUM_CH(NUM_CH), .NREG(NREG), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hold_ni(hold_n), .evt_i(evt),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq), .irq_oe_o(irq_oe)
  );

  // reference model
  logic [DW-1:0]   m_st[NUM_CH][NREG];
  logic [DW-1:0]   m_bm[NUM_CH][NREG];
  logic [NREG-1:0] m_vm[NUM_CH];
  logic            m_en[NUM_CH], m_lv[NUM_CH];
  logic            m_oe;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_oe <= 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        m_vm[c] <= '0; m_en[c] <= 1'b0; m_lv[c] <= 1'b0;
        for (int r = 0; r < NREG; r++) begin m_st[c][r] <= '0; m_bm[c][r] <= '0; end
      end
    end else begin
      automatic logic any = 1'b0;
      for (int c = 0; c < NUM_CH; c++)
        for (int r = 0; r < NREG; r++)
          if (m_st[c][r] != '0 && !m_vm[c][r] && m_en[c]) any = 1'b1;
      m_oe <= any && hold_n;
      for (int c = 0; c < NUM_CH; c++)
        for (int r = 0; r < NREG; r++) begin
          automatic logic hit = rd_en && t_ch == c && t_sp == 0 && t_rg == r;
          if (!hold_n || !m_lv[c]) m_st[c][r] <= '0;
          else m_st[c][r] <= (hit ? '0 : m_st[c][r]) | (evt[(c*NREG+r)*DW +: DW] & ~m_bm[c][r]);
        end
      if (wr_en) begin
        if (t_sp == 1 && t_rg < NREG) m_bm[t_ch][t_rg] <= wdata;
        if (t_sp == 2) m_vm[t_ch] <= wdata[NREG-1:0];
        if (t_sp == 3) begin
          if (wdata[2]) begin
            m_en[t_ch] <= 1'b0; m_lv[t_ch] <= 1'b0; m_vm[t_ch] <= '0;
            for (int r = 0; r < NREG; r++) m_bm[t_ch][r] <= '0;
          end else begin
            m_en[t_ch] <= wdata[0]; m_lv[t_ch] <= wdata[1];
          end
        end
      end
    end
  end

  function automatic logic [DW-1:0] model_read(int c, int sp, int r);
    case (sp)
      0: return (r < NREG) ? m_st[c][r] : '0;
      1: return (r < NREG) ? m_bm[c][r] : '0;
      2: return DW'(m_vm[c]);
      default: return DW'({m_lv[c], m_en[c]});
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq_oe == m_oe, "R2 irq_oe", 32'(irq_oe), 32'(m_oe));
      chk(irq == 1'b0, "R2 irq data", 32'(irq), 32'h0);
      if (rvalid) begin
        if (q_exp.size() == 0) chk(1'b0, "R3 unexpected rvalid", 32'h1, 32'h0);
        else begin
          automatic logic [DW-1:0] e = q_exp.pop_front();
          automatic string tg = q_tag.pop_front();
          chk(rdata == e, tg, 32'(rdata), 32'(e));
        end
      end
    end
  end

  task automatic set_addr(int c, int sp, int r);
    t_ch = c; t_sp = sp; t_rg = r;
    addr = {CH_W'(c), 2'(sp), RG_W'(r)};
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int c, int sp, int r, logic [DW-1:0] d);
    @(negedge clk);
    set_addr(c, sp, r); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int c, int sp, int r, string tag);
    @(negedge clk);
    set_addr(c, sp, r); rd_en = 1'b1;
    q_exp.push_back(model_read(c, sp, r)); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(int c, int r, logic [DW-1:0] v);
    @(negedge clk);
    evt[(c*NREG+r)*DW +: DW] = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd_with_evt(int c, int r, logic [DW-1:0] v, string tag);
    @(negedge clk);
    set_addr(c, 0, r); rd_en = 1'b1;
    evt[(c*NREG+r)*DW +: DW] = v;
    q_exp.push_back(model_read(c, 0, r)); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(irq_oe == 1'b0, "R10 reset irq_oe", 32'(irq_oe), 32'h0);
    rd(0, 3, 0, "R10 reset control");
    rd(1, 1, 2, "R10 reset bit mask");
    rd(0, 2, 0, "R10 reset vector mask");

    wr(0, 3, 0, 16'h3);
    wr(1, 3, 0, 16'h3);
    // R1/R2/R3 basic set, request, clear on read
    pulse(0, 1, 16'h0005);
    idle(2);
    chk(irq_oe == 1'b1, "R2 request after event", 32'(irq_oe), 32'h1);
    rd(0, 0, 1, "R1 status value");
    idle(2);
    chk(irq_oe == 1'b0, "R3 request gone after read", 32'(irq_oe), 32'h0);
    rd(0, 0, 1, "R3 status cleared");

    // R1 bit mask
    wr(0, 1, 0, 16'h00FF);
    pulse(0, 0, 16'h0F0F);
    rd(0, 0, 0, "R1 masked bits stay clear");

    // R4 several registers across channels
    pulse(0, 2, 16'h8000);
    pulse(1, 0, 16'h0011);
    idle(1);
    rd(0, 0, 2, "R4 first register");
    idle(2);
    chk(irq_oe == 1'b1, "R4 request held with one pending", 32'(irq_oe), 32'h1);
    rd(1, 0, 0, "R4 last register");
    idle(2);
    chk(irq_oe == 1'b0, "R4 request released", 32'(irq_oe), 32'h0);

    // R5 read and event collide
    pulse(1, 1, 16'h0001);
    rd_with_evt(1, 1, 16'h0002, "R5 read returns old value");
    idle(1);
    chk(irq_oe == 1'b1, "R5 request kept by new bit", 32'(irq_oe), 32'h1);
    rd(1, 0, 1, "R5 new bit survived");
    idle(2);

    // R6 vector mask
    wr(0, 2, 0, 16'h0002);
    pulse(0, 1, 16'h0008);
    idle(3);
    chk(irq_oe == 1'b0, "R6 masked register quiet", 32'(irq_oe), 32'h0);
    rd(0, 0, 1, "R6 status still set");
    rd(0, 2, 0, "R6 vector mask readback");
    wr(0, 2, 0, 16'h0000);

    // R7 channel disabled
    wr(1, 3, 0, 16'h2);
    pulse(1, 2, 16'h0040);
    idle(3);
    chk(irq_oe == 1'b0, "R7 disabled channel quiet", 32'(irq_oe), 32'h0);
    rd(1, 0, 2, "R7 status still set");
    rd(1, 0, 2, "R7 read cleared");
    wr(1, 3, 0, 16'h3);

    // R8 live bit low
    wr(0, 3, 0, 16'h1);
    pulse(0, 2, 16'hF000);
    idle(2);
    chk(irq_oe == 1'b0, "R8 no request", 32'(irq_oe), 32'h0);
    rd(0, 0, 2, "R8 status held clear");
    wr(0, 3, 0, 16'h3);

    // R9 global hold
    pulse(1, 0, 16'h0003);
    idle(2);
    chk(irq_oe == 1'b1, "R9 request before hold", 32'(irq_oe), 32'h1);
    @(negedge clk);
    hold_n = 1'b0;
    evt[(0*NREG+2)*DW +: DW] = 16'h0100;
    @(negedge clk);
    chk(irq_oe == 1'b0, "R9 request dropped by hold", 32'(irq_oe), 32'h0);
    @(negedge clk);
    evt = '0;
    hold_n = 1'b1;
    idle(1);
    rd(1, 0, 0, "R9 status cleared by hold");
    rd(0, 0, 2, "R9 event ignored under hold");
    rd(0, 1, 0, "R9 bit mask kept");

    // R10 channel reset
    wr(0, 3, 0, 16'h4);
    rd(0, 3, 0, "R10 channel reset control");
    rd(0, 1, 0, "R10 channel reset bit mask");
    rd(1, 3, 0, "R10 other channel untouched");

    idle(4);
    chk(q_exp.size() == 0, "R3 all reads answered", 32'(q_exp.size()), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule